// File: doc/BRIEF.md
# Level-Shifted Multicarrier PWM Modulator

The block drives a three-phase, nine-level cascaded H-bridge inverter. Each phase has a signed reference sample. Every cycle, the block compares each reference against a stack of eight carriers. The carriers all have the same frequency and the same peak-to-peak height, and they are stacked so that their bands touch without gaps or overlap. Each band produces one on/off command. The command is on while the reference is above that band's carrier and off while it is below. Summed over the four series cells, the commands give a phase level from -4 to +4 times the cell voltage.

All phases share one carrier phase input, which counts through one carrier period. A two-bit disposition selector sets which bands run their carrier 180 degrees out of phase. A one-bit shape selector picks a triangular carrier or a nine-step staircase approximation of it. Both selectors are taken only at a carrier period boundary. The reference generator, dead-time insertion and the mapping of band commands to individual switches are outside this block.

Top module: `mlpwm_top`

## Requirements
- R1: While `rst_ni` is low, every band bit is 0 and every level output is -4; the active disposition is 0 and the active shape is triangular.
- R2: The band bit for band k is registered and appears one clock after its inputs are sampled. It is 1 when the reference is strictly greater than band k's carrier and 0 when it is strictly smaller.
- R3: When the reference equals a band's carrier exactly, that band's bit keeps its previous value.
- R4: With the default 12-bit reference, band k covers values from -2048 + 512·k upward. The carrier value is the band floor plus an offset t in 0..511. The triangular offset is t = ph for ph below 512 and t = 1023 - ph otherwise. An inverted band uses 511 - t. As a result, a reference at the minimum value -2048 leaves bands 1 to 7 off.
- R5: Disposition code 0 runs every band non-inverted (all carriers in phase).
- R6: Disposition code 1 runs every band inverted (all in phase with one another, opposite to code 0).
- R7: Disposition code 2 runs bands 4 to 7 (above zero) non-inverted and bands 0 to 3 (below zero) inverted.
- R8: Disposition code 3 runs even-numbered bands non-inverted and odd-numbered bands inverted, so neighbouring bands are opposite.
- R9: Shape code 1 selects the staircase carrier. Its offset is the triangular or inverted offset rounded to the nearest multiple of 64, with halves rounded up, giving nine steps from 0 to 512. Shape code 0 selects the triangle.
- R10: Each phase's level output equals the number of its set band bits minus 4. The set bits always form a contiguous run that starts at band 0.
- R11: The disposition and shape inputs are captured only in a cycle where the carrier phase is 0, and they already apply to that cycle's comparison. In every other cycle the last captured values apply.
- R12: The three phases use the same carriers, and each phase's bits depend only on its own reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Carrier disposition code (0..3) |
| shape_i | input | 1 | Carrier shape: 0 triangle, 1 staircase |
| ph_i | input | PH_W (10) | Shared carrier phase; 0 marks a period boundary |
| ref_i | input | N_PH×DATA_W (3×12) | Signed reference per phase, phase p in slice p |
| bits_o | output | N_PH×N_BANDS (3×8) | Band on/off commands per phase, band k in bit k |
| level_o | output | N_PH×LVL_W (3×4) | Signed level per phase, -4..+4 |

## Verification
Band bits and levels appear one clock after the inputs they depend on are sampled. The behavioural model in the bench computes its expected state at the same rising edge as the design. It compares every phase at the following falling edge, before it drives new inputs, so each expected value lines up with the registered output it describes. A mode or shape change is applied by the model at the phase-0 edge where the design captures it, and that change is visible one clock later, like any other result. The equality-hold cases hold the carrier phase still, so that a reference placed exactly on a carrier keeps its bit across several of these one-cycle windows.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;
  typedef enum logic [1:0] {
    DISP_ALIGNED   = 2'd0,
    DISP_FLIPPED   = 2'd1,
    DISP_SPLIT     = 2'd2,
    DISP_ALTERNATE = 2'd3
  } disp_e;

  // band k inverted under disposition d, n bands in the stack
  function automatic logic band_inverted(disp_e d, int k, int n);
    case (d)
      DISP_ALIGNED:   return 1'b0;
      DISP_FLIPPED:   return 1'b1;
      DISP_SPLIT:     return (k < n / 2);
      default:        return (k % 2) == 1;
    endcase
  endfunction
endpackage

// File: rtl/mlpwm_carrier.sv
module mlpwm_carrier #(
  parameter int PH_W = 10,
  parameter int HB   = 9
) (
  input  logic [PH_W-1:0] ph_i,
  input  logic            stair_i,
  output logic [HB:0]     off_up_o,
  output logic [HB:0]     off_dn_o
);
  localparam int TRI_W = PH_W - 1;
  localparam int QL    = HB - 3;

  logic [TRI_W-1:0] tri_raw;
  logic [HB-1:0]    tri_up, tri_dn;

  assign tri_raw = ph_i[PH_W-1] ? ~ph_i[TRI_W-1:0] : ph_i[TRI_W-1:0];

  generate
    if (TRI_W >= HB) begin : g_trunc
      assign tri_up = tri_raw[TRI_W-1 -: HB];
    end else begin : g_pad
      assign tri_up = {tri_raw, {(HB-TRI_W){1'b0}}};
    end
  endgenerate

  assign tri_dn = ~tri_up;

  // round to nearest of eight steps per band
  function automatic logic [HB:0] to_stair(logic [HB-1:0] t);
    logic [HB:0] s;
    s = {1'b0, t} + (HB+1)'(1 << (QL - 1));
    return {s[HB:QL], {QL{1'b0}}};
  endfunction

  assign off_up_o = stair_i ? to_stair(tri_up) : {1'b0, tri_up};
  assign off_dn_o = stair_i ? to_stair(tri_dn) : {1'b0, tri_dn};
endmodule

// File: rtl/mlpwm_phase.sv
module mlpwm_phase
  import mlpwm_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int N_BANDS = 8,
  parameter int HB      = 9,
  parameter int LVL_W   = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [DATA_W-1:0] ref_i,
  input  logic [HB:0]              off_up_i,
  input  logic [HB:0]              off_dn_i,
  input  disp_e                    disp_i,
  output logic [N_BANDS-1:0]       bits_o,
  output logic [LVL_W-1:0]         level_o
);
  localparam int CW    = DATA_W + 2;
  localparam int CNT_W = $clog2(N_BANDS + 1);

  logic signed [CW-1:0] ref_ext;
  logic [N_BANDS-1:0]   bits_q;

  assign ref_ext = {{2{ref_i[DATA_W-1]}}, ref_i};

  for (genvar k = 0; k < N_BANDS; k++) begin : g_band
    localparam int FLOOR = -(2 ** (DATA_W - 1)) + k * (2 ** HB);
    logic                 inv;
    logic [HB:0]          off;
    logic signed [CW-1:0] car;

    assign inv = band_inverted(disp_i, k, N_BANDS);
    assign off = inv ? off_dn_i : off_up_i;
    assign car = $signed(CW'(FLOOR)) + $signed({{(CW-HB-1){1'b0}}, off});

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            bits_q[k] <= 1'b0;
      else if (ref_ext > car) bits_q[k] <= 1'b1;
      else if (ref_ext < car) bits_q[k] <= 1'b0;
    end
  end

  logic [CNT_W-1:0] cnt;
  always_comb begin
    cnt = '0;
    for (int k = 0; k < N_BANDS; k++) cnt = cnt + CNT_W'(bits_q[k]);
  end

  assign bits_o  = bits_q;
  assign level_o = LVL_W'(cnt) - LVL_W'(N_BANDS / 2);
endmodule

// File: rtl/mlpwm_top.sv
module mlpwm_top
  import mlpwm_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int N_BANDS = 8,
  parameter int N_PH    = 3,
  parameter int PH_W    = 10,
  parameter int LVL_W   = $clog2(N_BANDS / 2 + 1) + 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [1:0]                        mode_i,
  input  logic                              shape_i,
  input  logic [PH_W-1:0]                   ph_i,
  input  logic [N_PH-1:0][DATA_W-1:0]       ref_i,
  output logic [N_PH-1:0][N_BANDS-1:0]      bits_o,
  output logic [N_PH-1:0][LVL_W-1:0]        level_o
);
  localparam int HB = DATA_W - $clog2(N_BANDS);

  disp_e       disp_q, disp_eff;
  logic        stair_q, stair_eff;
  logic        boundary;
  logic [HB:0] off_up, off_dn;

  assign boundary  = (ph_i == '0);
  assign disp_eff  = boundary ? disp_e'(mode_i) : disp_q;
  assign stair_eff = boundary ? shape_i : stair_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_q  <= DISP_ALIGNED;
      stair_q <= 1'b0;
    end else if (boundary) begin
      disp_q  <= disp_e'(mode_i);
      stair_q <= shape_i;
    end
  end

  mlpwm_carrier #(.PH_W(PH_W), .HB(HB)) u_carrier (
    .ph_i     (ph_i),
    .stair_i  (stair_eff),
    .off_up_o (off_up),
    .off_dn_o (off_dn)
  );

  for (genvar p = 0; p < N_PH; p++) begin : g_phase
    mlpwm_phase #(
      .DATA_W (DATA_W),
      .N_BANDS(N_BANDS),
      .HB     (HB),
      .LVL_W  (LVL_W)
    ) u_phase (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ref_i    (ref_i[p]),
      .off_up_i (off_up),
      .off_dn_i (off_dn),
      .disp_i   (disp_eff),
      .bits_o   (bits_o[p]),
      .level_o  (level_o[p])
    );
  end
endmodule

// File: rtl/mlpwm_chk.sv
module mlpwm_chk #(
  parameter int DATA_W  = 12,
  parameter int N_BANDS = 8,
  parameter int N_PH    = 3,
  parameter int PH_W    = 10
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [PH_W-1:0]              ph_i,
  input logic [N_PH-1:0][DATA_W-1:0]  ref_i,
  input logic [N_PH-1:0][N_BANDS-1:0] bits_o,
  input logic [1:0]                   disp_q,
  input logic                         stair_q
);
  localparam logic [DATA_W-1:0] REF_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  for (genvar p = 0; p < N_PH; p++) begin : g_ph
    AST_THERMO_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((bits_o[p] & (bits_o[p] + 1'b1)) == '0)); // R10
    AST_FLOOR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ref_i[p] == REF_MIN) |=> (bits_o[p][N_BANDS-1:1] == '0)); // R4
  end

  AST_DISP_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(disp_q) |-> ($past(ph_i) == '0)); // R11
  AST_SHAPE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(stair_q) |-> ($past(ph_i) == '0)); // R11
endmodule

bind mlpwm_top mlpwm_chk #(
  .DATA_W (DATA_W),
  .N_BANDS(N_BANDS),
  .N_PH   (N_PH),
  .PH_W   (PH_W)
) u_mlpwm_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ph_i   (ph_i),
  .ref_i  (ref_i),
  .bits_o (bits_o),
  .disp_q (disp_q),
  .stair_q(stair_q)
);

// File: tb/test_mlpwm_top.sv
module test_mlpwm_top;
  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       mode;
  logic             shape;
  logic [9:0]       ph;
  logic [2:0][11:0] refv;
  logic [2:0][7:0]  bits;
  logic [2:0][3:0]  lvl;

  int    n_chk = 0;
  int    n_err = 0;
  int    n     = 0;
  string cur   = "R1";

  bit exp_b [3][8];
  int act_mode, act_shape;

  always #4 clk = ~clk;

  mlpwm_top i_mlpwm_top (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .mode_i (mode),
    .shape_i(shape),
    .ph_i   (ph),
    .ref_i  (refv),
    .bits_o (bits),
    .level_o(lvl)
  );

  function automatic int car_val(int k, int phv, int shp, int md);
    int  t;
    bit  flip;
    t = (phv < 512) ? phv : 1023 - phv;
    case (md)
      0: flip = 0;
      1: flip = 1;
      2: flip = (k < 4);
      default: flip = (k % 2 == 1);
    endcase
    if (flip) t = 511 - t;
    if (shp != 0) t = ((t + 32) / 64) * 64;
    return -2048 + 512 * k + t;
  endfunction

  function automatic int sval(logic [11:0] v);
    return int'($signed(v));
  endfunction

  // reference model: state after each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      act_mode  = 0;
      act_shape = 0;
      for (int p = 0; p < 3; p++) for (int k = 0; k < 8; k++) exp_b[p][k] = 0;
    end else begin
      if (ph == 0) begin
        act_mode  = int'(mode);
        act_shape = int'(shape);
      end
      for (int p = 0; p < 3; p++)
        for (int k = 0; k < 8; k++) begin
          int c;
          c = car_val(k, int'(ph), act_shape, act_mode);
          if (sval(refv[p]) > c) exp_b[p][k] = 1;
          else if (sval(refv[p]) < c) exp_b[p][k] = 0;
        end
    end
  end

  task automatic check_all();
    for (int p = 0; p < 3; p++) begin
      logic [7:0] ev;
      int         ones;
      ones = 0;
      for (int k = 0; k < 8; k++) begin
        ev[k] = exp_b[p][k];
        ones += exp_b[p][k];
      end
      n_chk++;
      if (bits[p] !== ev) begin
        n_err++;
        $display("FAIL %s R2 R12 phase %0d bits actual=%b expected=%b", cur, p, bits[p], ev);
      end
      n_chk++;
      if ($signed(lvl[p]) !== 4'(ones - 4)) begin
        n_err++;
        $display("FAIL %s R10 phase %0d level actual=%0d expected=%0d", cur, p,
                 $signed(lvl[p]), ones - 4);
      end
    end
  endtask

  task automatic drive(int phv, int m, int s, int r0, int r1, int r2);
    @(negedge clk);
    check_all();
    ph      = 10'(phv);
    mode    = 2'(m);
    shape   = 1'(s);
    refv[0] = 12'(r0);
    refv[1] = 12'(r1);
    refv[2] = 12'(r2);
  endtask

  function automatic int ramp(int i, int p);
    return ((i * 37 + p * 1365) % 4096) - 2048;
  endfunction

  initial begin
    string tags [4];
    tags[0] = "R5"; tags[1] = "R6"; tags[2] = "R7"; tags[3] = "R8";
    rst_n = 1'b0; mode = '0; shape = 1'b0; ph = '0; refv = '0;

    cur = "R1";
    for (int i = 0; i < 4; i++) drive(0, 2, 1, 1000, -5, 700);
    rst_n = 1'b1;

    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 4; m++) begin
        cur = (s != 0) ? "R9" : tags[m];
        for (int phv = 0; phv < 1024; phv++) begin
          drive(phv, m, s, ramp(n, 0), ramp(n, 1), ramp(n, 2));
          n++;
        end
      end

    cur = "R11";
    for (int phv = 0; phv < 1024; phv++) begin
      drive(phv, (phv < 500) ? 3 : 0, (phv < 700) ? 0 : 1,
            ramp(n, 0), ramp(n, 1), ramp(n, 2));
      n++;
    end
    for (int phv = 0; phv < 200; phv++) begin
      drive(phv, 1, 0, ramp(n, 0), ramp(n, 1), ramp(n, 2));
      n++;
    end

    // carrier of band 4 sits at 100 while ph stays 100
    cur = "R3";
    drive(0, 0, 0, 0, 0, 0);
    drive(100, 0, 0, 200, -1948, 100);
    drive(100, 0, 0, 100, -1948, 100);
    drive(100, 0, 0, 100, -1948, 100);
    drive(100, 0, 0, 50, -1949, 101);
    drive(100, 0, 0, 100, -1948, 100);
    drive(100, 0, 0, 100, -1948, 100);

    cur = "R4";
    drive(0, 0, 0, -2048, 2047, -1);
    drive(37, 0, 0, -2048, 2047, 0);
    drive(511, 0, 0, -1537, 1535, -512);
    drive(512, 0, 0, -1536, 1536, 512);
    drive(1023, 0, 0, -2048, 2047, 1);
    drive(0, 3, 1, -2048, 2047, 0);
    drive(511, 3, 1, -2048, 2047, 0);
    drive(256, 3, 1, -1024, 1024, 256);
    drive(256, 3, 1, -1024, 1024, 256);

    @(negedge clk);
    check_all();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog %s actual=running expected=finished", cur);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule